// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent down-counters behind a plain register bus (write strobe, read strobe, byte address, write data, read data). Timer 0 serves as a time base: loaded with all ones and placed on auto-reload, it wraps forever, and software reads its complement as a rising count. Timer 1 is the event timer. It runs either as a one-shot delay or as a periodic tick, and each expiry raises a sticky interrupt flag.

One shared control word holds a run bit and an auto-reload bit for each timer. Each timer also has a reload register and a current-value register. A write to the current-value register loads the counter at once. When the counter reaches zero with auto-reload set, it restarts from the reload register. Without auto-reload it stays at zero until software writes a new value.

Top module: `dual_timer`

## Requirements
- R1: After reset the control word, both counters, both reload registers and the interrupt flag are zero, and `irq` is low.
- R2: The control word is at offset 0x00. Bit 0 runs timer 0, bit 1 selects auto-reload for timer 0, bit 2 runs timer 1 and bit 3 selects auto-reload for timer 1. Reads return these four bits in the low positions and zeros above them.
- R3: Timer 0 has its reload register at 0x10 and its value register at 0x14. Timer 1 has its reload register at 0x18 and its value register at 0x1C. A read strobe captures the addressed register at the clock edge, and `rdata` holds that value from then on. Offsets with no register read as zero.
- R4: A running counter that is above zero decreases by exactly one per clock.
- R5: A counter whose run bit is clear keeps its value unchanged.
- R6: With auto-reload set, a running counter at zero takes the reload value on the next clock. Loading N-1 into both the reload and value registers therefore gives an expiry every N clocks.
- R7: One-shot mode has auto-reload clear. A delay D in the range 1 to 0xFFFFFFFE that is written to the value register gives exactly one expiry, in the D-th clock after the timer starts running. The counter then stays at zero and raises no further expiry until the value register is written again.
- R8: A counter running on auto-reload from a reload value of all ones passes from zero to 0xFFFFFFFF and keeps counting down.
- R9: A timer 1 expiry sets the interrupt flag (bit 0 at offset 0x04) on the next clock, and `irq` follows the flag. Writing 1 to that bit clears the flag and writing 0 has no effect. An expiry in the same clock as a clear leaves the flag set.
- R10: Expiries of timer 0 never touch the interrupt flag.
- R11: A value-register write in a clock where that timer is running loads the written value, and no decrement is applied in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; captures the addressed register into `rdata` |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data held from the last read strobe |
| irq | output | 1 | Level interrupt from the timer 1 flag |

## Verification
The bench checks the exact count reached after a known number of running clocks. A counter that loses a decrement on the clock that starts it or the clock that stops it would read one off. It also checks the clock-for-clock point where a one-shot raises the flag, and that the flag stays clear after it is acknowledged. A one-shot that fired again while parked at zero would set the flag a second time. The periodic case runs past a reload, so a period of N+1 would leave a different frozen value. The free-run case crosses the wrap to all ones, which catches a counter that sticks at zero. Further checks cover a load while running (a design that also decremented would read one low) and a write of 0 to the flag (a design that cleared on any write would drop `irq`).

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int unsigned ADDR_W = 5;

    // Field order makes run0 bit 0 ... reload1 bit 3
    typedef struct packed {
        logic rel1;
        logic run1;
        logic rel0;
        logic run0;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RLD0 = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_VAL0 = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_RLD1 = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_VAL1 = 5'h1C;

endpackage

// File: rtl/dtmr_core.sv
module dtmr_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             autoreload_i,
    input  logic             val_we_i,
    input  logic             rld_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             armed;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        at_zero;

    always_comb begin
        st_d     = st_q;
        at_zero  = (st_q.cnt == '0);
        expire_o = run_i && at_zero && (autoreload_i || st_q.armed);

        if (rld_we_i) begin
            st_d.rld = wdata_i;
        end

        if (val_we_i) begin
            st_d.cnt   = wdata_i;
            st_d.armed = 1'b1;
        end else if (run_i) begin
            if (!at_zero) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end else if (autoreload_i) begin
                st_d.cnt = st_q.rld;
            end else begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.cnt;
    assign reload_o = st_q.rld;

endmodule

// File: rtl/dtmr_flag.sv
module dtmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i) begin
            flag_d = 1'b1;
        end else if (clr_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam int unsigned NTMR = 2;
    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] rdata;
    } top_state_t;

    top_state_t       top_d, top_q;
    ctrl_t            ctrl_w;
    logic [NTMR-1:0]  run_w, rel_w, val_we_w, rld_we_w, expire_w;
    logic [CNT_W-1:0] count_w  [NTMR];
    logic [CNT_W-1:0] reload_w [NTMR];
    logic             flag_w;
    logic             flag_clr_w;

    assign ctrl_w = top_q.ctrl;
    assign run_w  = {ctrl_w.run1, ctrl_w.run0};
    assign rel_w  = {ctrl_w.rel1, ctrl_w.rel0};

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        localparam logic [ADDR_W-1:0] VAL_OFS = (g == 0) ? OFS_VAL0 : OFS_VAL1;
        localparam logic [ADDR_W-1:0] RLD_OFS = (g == 0) ? OFS_RLD0 : OFS_RLD1;

        assign val_we_w[g] = bus_wr && (bus_addr == VAL_OFS);
        assign rld_we_w[g] = bus_wr && (bus_addr == RLD_OFS);

        dtmr_core #(.CNT_W(CNT_W)) u_core (
            .clk          (clk),
            .rst_n        (rst_n),
            .run_i        (run_w[g]),
            .autoreload_i (rel_w[g]),
            .val_we_i     (val_we_w[g]),
            .rld_we_i     (rld_we_w[g]),
            .wdata_i      (bus_wdata),
            .count_o      (count_w[g]),
            .reload_o     (reload_w[g]),
            .expire_o     (expire_w[g])
        );
    end

    assign flag_clr_w = bus_wr && (bus_addr == OFS_FLAG) && bus_wdata[0];

    dtmr_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (expire_w[1]),
        .clr_i  (flag_clr_w),
        .flag_o (flag_w)
    );

    always_comb begin
        top_d = top_q;
        if (bus_wr && (bus_addr == OFS_CTRL)) begin
            top_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
        if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL: top_d.rdata = {{(CNT_W-CTRL_W){1'b0}}, top_q.ctrl};
                OFS_FLAG: top_d.rdata = {{(CNT_W-1){1'b0}}, flag_w};
                OFS_RLD0: top_d.rdata = reload_w[0];
                OFS_VAL0: top_d.rdata = count_w[0];
                OFS_RLD1: top_d.rdata = reload_w[1];
                OFS_VAL1: top_d.rdata = count_w[1];
                default:  top_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_rdata = top_q.rdata;
    assign irq       = flag_w;

endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
    import dtmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  cnt0,
    input logic [CNT_W-1:0]  cnt1,
    input logic [CNT_W-1:0]  rld1,
    input logic [1:0]        expire,
    input logic              irq
);

    logic wr_val0, wr_val1, wr_clr;
    assign wr_val0 = bus_wr && (bus_addr == OFS_VAL0);
    assign wr_val1 = bus_wr && (bus_addr == OFS_VAL1);
    assign wr_clr  = bus_wr && (bus_addr == OFS_FLAG) && bus_wdata[0];

    // R5
    freeze0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run0 && !wr_val0) |=> $stable(cnt0));

    // R5
    freeze1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run1 && !wr_val1) |=> $stable(cnt1));

    // R4
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run1 && cnt1 != '0 && !wr_val1) |=> (cnt1 == $past(cnt1) - CNT_W'(1)));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run1 && ctrl.rel1 && cnt1 == '0 && !wr_val1) |=> (cnt1 == $past(rld1)));

    // R7
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run1 && !ctrl.rel1 && cnt1 == '0 && !wr_val1) |=> (cnt1 == '0));

    // R7
    oneshot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire[1] && !ctrl.rel1 && !bus_wr) |=> !expire[1]);

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val0 |=> (cnt0 == $past(bus_wdata)));

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire[1] |=> irq);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !expire[1]) |=> !irq);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !expire[1]) |=> !irq);

endmodule

bind dual_timer dual_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl      (ctrl_w),
    .cnt0      (count_w[0]),
    .cnt1      (count_w[1]),
    .rld1      (reload_w[1]),
    .expire    (expire_w),
    .irq       (irq)
);

// File: tb/dual_timer_bench.sv
module dual_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_timer u_dual_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(5'h00, v); check("R1 ctrl", v, 32'h0);
        rd(5'h04, v); check("R1 flag", v, 32'h0);
        rd(5'h10, v); check("R1 rld0", v, 32'h0);
        rd(5'h14, v); check("R1 val0", v, 32'h0);
        rd(5'h18, v); check("R1 rld1", v, 32'h0);
        rd(5'h1C, v); check("R1 val1", v, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_FFFA);
        rd(5'h00, v); check("R2 ctrl bits", v, 32'h0000_000A);
        wr(5'h00, 32'h0);
        wr(5'h18, 32'h1234_5678);
        rd(5'h18, v); check("R3 rld1", v, 32'h1234_5678);
        wr(5'h10, 32'h0BAD_F00D);
        rd(5'h10, v); check("R3 rld0", v, 32'h0BAD_F00D);
        rd(5'h0C, v); check("R3 unmapped", v, 32'h0);
    endtask

    task automatic t_count_freeze();
        logic [31:0] v;
        wr(5'h14, 32'd100);
        wr(5'h00, 32'h1);
        idle(9);
        wr(5'h00, 32'h0);
        rd(5'h14, v); check("R4 count after 10 clocks", v, 32'd90);
        idle(5);
        rd(5'h14, v); check("R5 frozen", v, 32'd90);
        wr(5'h00, 32'h1);
        wr(5'h14, 32'h55);
        rd(5'h14, v); check("R11 load while running", v, 32'h55);
        wr(5'h00, 32'h0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(5'h18, 32'd4);
        wr(5'h1C, 32'd4);
        wr(5'h00, 32'hC);
        idle(6);
        wr(5'h00, 32'h0);
        rd(5'h1C, v); check("R6 period 5 after 7 clocks", v, 32'd2);
        check("R9 irq set", {31'b0, irq}, 32'h1);
        wr(5'h04, 32'h0);
        check("R9 write 0 keeps flag", {31'b0, irq}, 32'h1);
        wr(5'h04, 32'h1);
        check("R9 write 1 clears", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(5'h1C, 32'd3);
        wr(5'h00, 32'h4);
        idle(3);
        check("R7 no early expiry", {31'b0, irq}, 32'h0);
        idle(1);
        check("R7 expiry after 3", {31'b0, irq}, 32'h1);
        wr(5'h04, 32'h1);
        idle(10);
        check("R7 no second expiry", {31'b0, irq}, 32'h0);
        rd(5'h1C, v); check("R7 holds zero", v, 32'h0);
        wr(5'h1C, 32'd2);
        idle(2);
        check("R7 rearm not early", {31'b0, irq}, 32'h0);
        idle(1);
        check("R7 rearm expiry", {31'b0, irq}, 32'h1);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h1);
    endtask

    task automatic t_freerun();
        logic [31:0] v;
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'd2);
        wr(5'h00, 32'h3);
        idle(3);
        wr(5'h00, 32'h0);
        rd(5'h14, v); check("R8 wrap", v, 32'hFFFF_FFFE);
        check("R8 complement up-count", ~v, 32'h1);
        check("R10 timer0 no irq", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_count_freeze();
        t_periodic();
        t_oneshot();
        t_freerun();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %h expected %h", 32'h1, 32'h0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule